// File: doc/BRIEF.md
# Integer Systolic Multiply-Accumulate Grid

This block is a two-dimensional, output-stationary grid of integer processing cells that builds convolution partial sums. Each cell owns one wide accumulator. Activation words stream in from the left edge, one stream per row, and move one column to the right each cycle. Weight words stream in from the top edge, one stream per column, and move one row down each cycle. Every word carries a valid flag. A cell that sees a valid activation and a valid weight in the same cycle adds their signed product to its accumulator.

The surrounding engine skews the operand streams. Element k of row r enters at cycle k + r. Element k of column c enters at cycle k + c. With this timing, cell (r, c) pairs the two streams correctly and ends up holding the preload value plus the dot product of activation row r and weight column c.

Accumulators are seeded by shifting preload values in from the left of each row. Results are read by shifting them out on the right, one value per row per cycle. If either operand is zero, the multiplier inputs are isolated and the accumulator register is not written, so neither stage toggles.

Top module: `sysmac_array`

## Requirements
- R1: After synchronous reset every accumulator holds zero and `res_vld` is low.
- R2: While `load` is high, each row shifts right by one cell per cycle. Column 0 takes the row's 16-bit `pre_data` word sign-extended to 34 bits. After COLS load cycles, column c holds the word presented on load cycle COLS-1-c.
- R3: With operands skewed as described (row r element k at cycle k+r, column c element k at cycle k+c), cell (r, c) ends holding its preload plus the sum over k of A[r][k]·B[k][c].
- R4: Operands are two's-complement signed 16-bit values. Products are formed exactly, including (-32768)·(-32768).
- R5: The 34-bit accumulator wraps modulo 2^34 on overflow, with no saturation.
- R6: When a valid operand pair contains a zero, the accumulator is left unchanged.
- R7: A cell whose activation or weight is not valid in a cycle keeps its accumulator, whatever the data lines carry.
- R8: While `drain` is high and `load` is low, `res_vld` is high and `res_data[r]` shows the rightmost cell of row r. Each cycle the row shifts right, with zero entering column 0, so values leave in order column COLS-1 down to 0.
- R9: Valid flags travel with their data: an activation advances one column per cycle and a weight one row per cycle, each with its own flag.
- R10: `load` has priority over `drain`, which has priority over multiply-accumulate. When `load` and `drain` are both high, preload shifting takes place and `res_vld` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Shift preload words into the rows |
| pre_data | input | ROWS×16 | Per-row signed preload word |
| act_in | input | ROWS×16 | Per-row signed activation word at column 0 |
| act_vld | input | ROWS | Per-row activation valid |
| wgt_in | input | COLS×16 | Per-column signed weight word at row 0 |
| wgt_vld | input | COLS | Per-column weight valid |
| drain | input | 1 | Shift accumulators out to the right |
| res_data | output | ROWS×34 | Rightmost accumulator of each row |
| res_vld | output | 1 | Result words are being shifted out |

## Verification
The bench builds the grid at its default 4×8 shape. This covers every cell, including both skew extremes and the full-length row shift for preload and drain. Reduction depth sweeps from 1 to 16, so the arithmetic runs from a single product up to enough extreme products to wrap the 34-bit accumulator. Operand patterns mix zeros, full-range values and per-element invalid flags. Each pattern is compared with a matrix-product model computed in 64-bit integers and reduced modulo 2^34.

// File: rtl/sysmac_pkg.sv
package sysmac_pkg;
    localparam int OPND_W = 16;
    localparam int PROD_W = 2 * OPND_W;
    localparam int ACC_W  = PROD_W + 2;

    typedef logic signed [OPND_W-1:0] opnd_val_t;
    typedef logic [ACC_W-1:0]         acc_t;

    typedef struct packed {
        logic      vld;
        opnd_val_t val;
    } opnd_t;

    // sign-extend an operand to accumulator width
    function automatic acc_t widen(opnd_val_t v);
        return {{(ACC_W-OPND_W){v[OPND_W-1]}}, v};
    endfunction

    // exact signed product, sign-extended to accumulator width
    function automatic acc_t product(opnd_val_t a, opnd_val_t b);
        logic signed [PROD_W-1:0] p;
        p = a * b;
        return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
    endfunction
endpackage

// File: rtl/sysmac_opnd_reg.sv
module sysmac_opnd_reg
    import sysmac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  opnd_t d,
    output opnd_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/sysmac_cell.sv
module sysmac_cell
    import sysmac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  opnd_t act_i,
    input  opnd_t wgt_i,
    input  logic  load,
    input  logic  drain,
    input  acc_t  side_i,
    output acc_t  acc_o
);
    acc_t      acc_q;
    logic      pair_ok;
    logic      nonzero;
    logic      mac_en;
    opnd_val_t iso_a;
    opnd_val_t iso_b;
    acc_t      prod;

    assign pair_ok = act_i.vld && wgt_i.vld;
    assign nonzero = (act_i.val != '0) && (wgt_i.val != '0);
    assign mac_en  = pair_ok && nonzero;

    // operand isolation keeps the multiplier quiet when gated
    assign iso_a = mac_en ? act_i.val : '0;
    assign iso_b = mac_en ? wgt_i.val : '0;
    assign prod  = product(iso_a, iso_b);

    always_ff @(posedge clk) begin
        if (rst)                 acc_q <= '0;
        else if (load || drain)  acc_q <= side_i;
        else if (mac_en)         acc_q <= acc_q + prod;
    end

    assign acc_o = acc_q;

    // R7
    hold_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        (!pair_ok && !load && !drain) |=> $stable(acc_q));

    // R6
    zero_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_ok && !nonzero && !load && !drain) |=> $stable(acc_q));

    // R3
    mac_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mac_en && !load && !drain) |=>
        acc_q == $past(acc_q + widen(act_i.val) * widen(wgt_i.val)));

    // R10
    side_move_chk: assert property (@(posedge clk) disable iff (rst)
        (load || drain) |=> acc_q == $past(side_i));
endmodule

// File: rtl/sysmac_array.sv
module sysmac_array
    import sysmac_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic [ROWS-1:0][OPND_W-1:0]   pre_data,
    input  logic [ROWS-1:0][OPND_W-1:0]   act_in,
    input  logic [ROWS-1:0]               act_vld,
    input  logic [COLS-1:0][OPND_W-1:0]   wgt_in,
    input  logic [COLS-1:0]               wgt_vld,
    input  logic                          drain,
    output logic [ROWS-1:0][ACC_W-1:0]    res_data,
    output logic                          res_vld
);
    opnd_t act_w [ROWS][COLS];
    opnd_t wgt_w [ROWS][COLS];
    acc_t  acc_w [ROWS][COLS];
    acc_t  side_w[ROWS][COLS];

    assign res_vld = drain && !load;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign act_w[r][0] = '{vld: act_vld[r], val: act_in[r]};
        assign res_data[r] = acc_w[r][COLS-1];

        for (genvar c = 0; c < COLS; c++) begin : g_col
            if (r == 0) begin : g_wtop
                assign wgt_w[0][c] = '{vld: wgt_vld[c], val: wgt_in[c]};
            end else begin : g_wpipe
                sysmac_opnd_reg u_wreg (
                    .clk (clk), .rst (rst),
                    .d   (wgt_w[r-1][c]),
                    .q   (wgt_w[r][c])
                );
            end

            if (c == 0) begin : g_left
                assign side_w[r][0] = load ? widen(pre_data[r]) : '0;
            end else begin : g_inner
                assign side_w[r][c] = acc_w[r][c-1];
                sysmac_opnd_reg u_areg (
                    .clk (clk), .rst (rst),
                    .d   (act_w[r][c-1]),
                    .q   (act_w[r][c])
                );
            end

            sysmac_cell u_cell (
                .clk    (clk),
                .rst    (rst),
                .act_i  (act_w[r][c]),
                .wgt_i  (wgt_w[r][c]),
                .load   (load),
                .drain  (drain),
                .side_i (side_w[r][c]),
                .acc_o  (acc_w[r][c])
            );
        end

        // R2
        load_edge_chk: assert property (@(posedge clk) disable iff (rst)
            load |=> acc_w[r][0] ==
                {{(ACC_W-OPND_W){$past(pre_data[r][OPND_W-1])}}, $past(pre_data[r])});

        if (COLS > 1) begin : g_drchk
            // R8
            drain_out_chk: assert property (@(posedge clk) disable iff (rst)
                (drain && !load) |=> res_data[r] == $past(acc_w[r][COLS-2]));
        end
    end

    // R9
    for (genvar r = 0; r < ROWS; r++) begin : g_fwd
        if (COLS > 1) begin : g_fa
            act_fwd_chk: assert property (@(posedge clk) disable iff (rst)
                act_vld[r] |=> act_w[r][1].vld && act_w[r][1].val == $past(act_in[r]));
        end
    end
endmodule

// File: tb/sysmac_array_test.sv
module sysmac_array_test;
    localparam int ROWS = 4;
    localparam int COLS = 8;
    localparam int KMAX = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load = 1'b0;
    logic drain = 1'b0;
    logic [ROWS-1:0][15:0] pre_data = '0;
    logic [ROWS-1:0][15:0] act_in = '0;
    logic [ROWS-1:0]       act_vld = '0;
    logic [COLS-1:0][15:0] wgt_in = '0;
    logic [COLS-1:0]       wgt_vld = '0;
    logic [ROWS-1:0][33:0] res_data;
    logic                  res_vld;

    always #4 clk = ~clk;

    sysmac_array #(.ROWS(ROWS), .COLS(COLS)) uut (
        .clk(clk), .rst(rst), .load(load), .pre_data(pre_data),
        .act_in(act_in), .act_vld(act_vld), .wgt_in(wgt_in), .wgt_vld(wgt_vld),
        .drain(drain), .res_data(res_data), .res_vld(res_vld)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic signed [15:0] A [ROWS][KMAX];
    logic signed [15:0] B [KMAX][COLS];
    bit                 am[ROWS][KMAX];
    bit                 bm[KMAX][COLS];
    logic signed [15:0] P [ROWS][COLS];
    logic [33:0]        E [ROWS][COLS];

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic signed [15:0] rnd_op(int mode);
        int unsigned u = $urandom;
        if (mode == 0) return (u % 4 == 0) ? 16'sd0 : 16'(signed'(int'(u % 41)) - 20);
        if (mode == 1) return (u % 5 == 0) ? 16'sd0 : 16'(u);
        return (u % 2 == 0) ? -16'sd32768 : 16'sd32767;
    endfunction

    task automatic make_exp(int K);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                longint s = longint'(P[r][c]);
                for (int k = 0; k < K; k++)
                    if (am[r][k] && bm[k][c])
                        s += longint'(A[r][k]) * longint'(B[k][c]);
                E[r][c] = s[33:0];
            end
    endtask

    // R2: column c ends holding the word given on load cycle COLS-1-c
    task automatic do_load(bit with_drain);
        for (int i = 0; i < COLS; i++) begin
            @(negedge clk);
            load = 1'b1;
            drain = with_drain;
            for (int r = 0; r < ROWS; r++) pre_data[r] = P[r][COLS-1-i];
            #1;
            // R10: load masks result valid
            if (with_drain) chk(res_vld == 1'b0, "R10 res_vld under load", res_vld, 0);
        end
        @(negedge clk);
        load = 1'b0;
        drain = 1'b0;
    endtask

    // R3 R9: skewed streaming of A rows and B columns
    task automatic run_mm(int K);
        for (int t = 0; t < K + ROWS + COLS + 1; t++) begin
            @(negedge clk);
            for (int r = 0; r < ROWS; r++) begin
                int k = t - r;
                if (k >= 0 && k < K) begin
                    act_in[r] = A[r][k]; act_vld[r] = am[r][k];
                end else begin
                    act_in[r] = 16'h7abc; act_vld[r] = 1'b0;
                end
            end
            for (int c = 0; c < COLS; c++) begin
                int k = t - c;
                if (k >= 0 && k < K) begin
                    wgt_in[c] = B[k][c]; wgt_vld[c] = bm[k][c];
                end else begin
                    wgt_in[c] = 16'h5a5a; wgt_vld[c] = 1'b0;
                end
            end
        end
    endtask

    // R8: values leave from column COLS-1 downward
    task automatic drain_check(string req);
        for (int i = 0; i < COLS; i++) begin
            @(negedge clk);
            drain = 1'b1;
            #1;
            chk(res_vld == 1'b1, "R8 res_vld", res_vld, 1);
            for (int r = 0; r < ROWS; r++)
                chk(res_data[r] == E[r][COLS-1-i], req,
                    longint'(res_data[r]), longint'(E[r][COLS-1-i]));
        end
        @(negedge clk);
        drain = 1'b0;
    endtask

    task automatic fill(int K, int mode, bit masked);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) P[r][c] = rnd_op(mode == 2 ? 1 : mode);
        for (int r = 0; r < ROWS; r++)
            for (int k = 0; k < KMAX; k++) begin
                A[r][k] = rnd_op(mode);
                am[r][k] = masked ? ($urandom % 4 != 0) : 1'b1;
            end
        for (int k = 0; k < KMAX; k++)
            for (int c = 0; c < COLS; c++) begin
                B[k][c] = rnd_op(mode);
                bm[k][c] = masked ? ($urandom % 4 != 0) : 1'b1;
            end
        make_exp(K);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        chk(res_vld == 1'b0, "R1 res_vld after reset", res_vld, 0);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) E[r][c] = '0;
        drain_check("R1 zero after reset");

        // R2 R4: preload sign extension, extremes included
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                P[r][c] = (c == 0) ? -16'sd32768 : (c == 1) ? -16'sd1 :
                          (c == 2) ? 16'sd32767 : 16'(r * 100 + c);
                E[r][c] = {{18{P[r][c][15]}}, P[r][c]};
            end
        do_load(1'b0);
        drain_check("R2 preload");
        // R8: drained rows are refilled with zero
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) E[r][c] = '0;
        drain_check("R8 zero fill after drain");

        // R3 R6: small values with many zeros, depth sweep
        for (int K = 1; K <= KMAX; K++) begin
            fill(K, 0, 1'b0);
            do_load(1'b0); run_mm(K); drain_check("R3 R6 small operands");
        end
        // R4: full-range signed operands
        for (int K = 1; K <= KMAX; K += 3) begin
            fill(K, 1, 1'b0);
            do_load(1'b0); run_mm(K); drain_check("R4 full range");
        end
        // R5: extreme operands wrap the accumulator
        for (int K = 9; K <= KMAX; K += 7) begin
            fill(K, 2, 1'b0);
            do_load(1'b0); run_mm(K); drain_check("R5 wrap");
        end
        begin
            int K = 12;
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) P[r][c] = 16'sd32767;
                for (int k = 0; k < KMAX; k++) begin A[r][k] = -16'sd32768; am[r][k] = 1; end
            end
            for (int k = 0; k < KMAX; k++)
                for (int c = 0; c < COLS; c++) begin B[k][c] = -16'sd32768; bm[k][c] = 1; end
            make_exp(K);
            do_load(1'b0); run_mm(K); drain_check("R5 wrap max");
        end
        // R7 R9: per-element invalid flags
        for (int K = 2; K <= KMAX; K += 2) begin
            fill(K, 1, 1'b1);
            do_load(1'b0); run_mm(K); drain_check("R7 R9 masked operands");
        end
        // R7: nothing valid at all
        fill(8, 1, 1'b0);
        for (int r = 0; r < ROWS; r++) for (int k = 0; k < KMAX; k++) am[r][k] = 0;
        make_exp(8);
        do_load(1'b0); run_mm(8); drain_check("R7 all invalid");
        // R10: load and drain together perform a load
        fill(1, 1, 1'b0);
        for (int r = 0; r < ROWS; r++) for (int k = 0; k < KMAX; k++) am[r][k] = 0;
        make_exp(1);
        do_load(1'b1);
        drain_check("R10 load over drain");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule